// File: doc/BRIEF.md
# SMBus Byte-Data Master

This block is a two-wire serial master with a small host register window. Software programs a configuration word (enable, 7-bit slave address, data width, SCL divider, acknowledge masking and a sensor-compatibility option). It then writes a command word holding a slave register address, write data and a read flag. That command write starts exactly one byte-data transaction on the bus. The clock and data lines are open-drain: the block only ever pulls a line low or releases it.

Progress and outcome are visible in the command word. A write-pending flag stays set for as long as a write is on the bus. A read-valid flag marks a finished read, and an error flag marks a slave that did not acknowledge. Every completion also sets sticky interrupt status bits. Software clears these by writing ones, and they drive a level interrupt through a mask register. Internally the transaction sequencer feeds bus primitives (START, STOP, byte out, byte in) to a bit engine over a valid/ready pair. The sequencer holds a primitive steady until the engine takes it.

Top module: `smbus_byte_master`

## Requirements
- R1: Register addresses are 0 = configuration, 1 = command, 2 = interrupt status, 3 = interrupt mask. Configuration bit 0 is enable. A command write starts a transaction only when enable is 1; with enable 0 it changes nothing and the bus stays idle.
- R2: A narrow write (configuration bit 1 = 0, command bit 24 = 0) produces START, address byte {cfg[9:3], 0}, register byte cmd[23:16], data byte cmd[7:0], STOP. All bytes go MSB first, and each is followed by an acknowledge slot.
- R3: With configuration bit 1 = 1 (16-bit mode), a write sends cmd[15:8] and then cmd[7:0]. A read receives two bytes: the master acknowledges the first and not the second, and the result is {first, second} in cmd[15:0].
- R4: Command bit 25 (write pending) is 1 from the cycle after a write launches until the write completes. Host writes to bits 25 to 27 do not set them.
- R5: A narrow read (command bit 24 = 1) produces START, {addr, 0}, register byte, repeated START, {addr, 1}, one received byte answered with no-acknowledge, STOP. Bit 26 (read valid) is then 1 and cmd[15:0] = {8'h00, received byte}.
- R6: With configuration bit 23 = 1, a read places STOP and then START between the register byte and the read address, instead of a repeated START.
- R7: When the slave leaves any sent byte unacknowledged, the master sets command bit 27 (error), issues STOP at once and sends nothing further. On a read, read valid stays 0 and cmd[15:0] keeps its launch value.
- R8: With configuration bit 22 = 1, a missing acknowledge is ignored and the transaction runs to its normal end with error 0.
- R9: Each completion sets interrupt status bit 0, and also bit 1 if the error flag is set. Writing 1 to a status bit clears it. The irq output is high when any status bit is set whose bit in the mask register (address 3) is also 1.
- R10: Each SCL low or high half lasts (D + 1) clock cycles, where D is configuration bits 18:10; a D of 0 is treated as 1.
- R11: A command write arriving while a transaction is running is ignored. It changes no command field and does not alter the bus sequence.
- R12: After reset, all registers read 0, irq is low, and both lines are released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 2 | Host register address (used for reads and writes) |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Level interrupt |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The assertions take for granted three things about the inputs: reset is applied before the first host write, the host reaches only the four defined addresses, and SDA from the slave changes only while SCL is low (apart from START and STOP, which only the master creates). The bench's slave model moves its SDA drive only in the sample after it sees SCL fall, and it releases the line before any STOP. Random dividers are kept between 0 and 6, and random transactions mix widths, directions, the compatibility option and refused acknowledges. This keeps every run within those limits.

// File: rtl/smbus_pkg.sv
package smbus_pkg;
  localparam int ADDR_W     = 7;
  localparam int DIV_W      = 9;
  localparam int DATA_W     = 16;
  localparam int EN_BIT     = 0;
  localparam int WIDE_BIT   = 1;
  localparam int SLV_LO     = 3;
  localparam int DIV_LO     = 10;
  localparam int MASK_BIT   = 22;
  localparam int COMPAT_BIT = 23;
  localparam int RADDR_LO   = 16;
  localparam int RD_BIT     = 24;
  localparam logic [31:0] CFG_KEEP = 32'h3
    | (((32'd1 << ADDR_W) - 1) << SLV_LO)
    | (((32'd1 << DIV_W) - 1) << DIV_LO)
    | (32'd1 << MASK_BIT) | (32'd1 << COMPAT_BIT);
  localparam logic [1:0] RA_CFG = 2'd0, RA_CMD = 2'd1, RA_IST = 2'd2, RA_IMASK = 2'd3;

  typedef enum logic [1:0] {OP_START, OP_STOP, OP_WRITE, OP_READ} bus_op_e;

  typedef struct packed {
    bus_op_e    op;
    logic [7:0] data;
    logic       last;   // read: answer with no-acknowledge
  } bus_cmd_t;
endpackage

// File: rtl/smbus_tick.sv
module smbus_tick import smbus_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt, lim;
  assign lim  = (div == '0) ? DIV_W'(1) : div;
  assign tick = (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || tick)  cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  // R10: a half period is never shorter than two cycles
  a_r10_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/smbus_bit_engine.sv
module smbus_bit_engine import smbus_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  bus_cmd_t   cmd,
  input  logic       tick,
  output logic       restart,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  output logic       rsp_ack,
  output logic       scl_drive,
  output logic       sda_drive,
  input  logic       sda_in
);
  logic       busy, last, scl_q, sda_i, sda_q, ack_q;
  bus_op_e    op;
  logic [1:0] ph;
  logic [3:0] bitn;
  logic [7:0] sh;
  logic       is_byte;

  assign cmd_ready = !busy;
  assign restart   = cmd_valid && !busy;
  assign is_byte   = (op == OP_WRITE) || (op == OP_READ);
  assign rsp_data  = sh;
  assign rsp_ack   = ack_q;
  assign scl_drive = scl_q;
  assign sda_drive = sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; last <= 1'b0; scl_q <= 1'b0; sda_i <= 1'b0; sda_q <= 1'b0;
      ack_q <= 1'b0; op <= OP_START; ph <= '0; bitn <= '0; sh <= '0; rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      sda_q     <= sda_i;          // data moves one cycle after the clock edge
      if (cmd_valid && !busy) begin
        busy  <= 1'b1;
        op    <= cmd.op;
        ph    <= '0;
        bitn  <= '0;
        sh    <= cmd.data;
        last  <= cmd.last;
        scl_q <= 1'b1;
        case (cmd.op)
          OP_START: sda_i <= 1'b0;
          OP_STOP:  sda_i <= 1'b1;
          OP_WRITE: sda_i <= ~cmd.data[7];
          default:  sda_i <= 1'b0;
        endcase
      end else if (busy && tick) begin
        if (!is_byte) begin
          if (ph == 2'd0) begin
            ph <= 2'd1; scl_q <= 1'b0;
          end else if (ph == 2'd1) begin
            ph <= 2'd2; sda_i <= (op == OP_START);
          end else begin
            busy <= 1'b0; rsp_valid <= 1'b1;
          end
        end else if (ph == 2'd0) begin
          ph <= 2'd1; scl_q <= 1'b0;
        end else begin
          if (bitn < 4'd8) sh <= {sh[6:0], sda_in};
          else             ack_q <= !sda_in;
          if (bitn == 4'd8) begin
            busy <= 1'b0; rsp_valid <= 1'b1;
          end else begin
            ph    <= 2'd0;
            bitn  <= bitn + 1'b1;
            scl_q <= 1'b1;
            if (bitn < 4'd7) sda_i <= (op == OP_WRITE) ? ~sh[6] : 1'b0;
            else             sda_i <= (op == OP_READ) ? ~last : 1'b0;
          end
        end
      end
    end
  end

  // R2: data never moves while SCL is released during a byte
  a_r2_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_byte && !scl_q && $past(!scl_q)) |-> $stable(sda_q));
  // R2: a finished primitive leaves the engine ready
  a_r2_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> cmd_ready);
endmodule

// File: rtl/smbus_sequencer.sv
module smbus_sequencer import smbus_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] slave,
  input  logic [7:0]        l_reg,
  input  logic [DATA_W-1:0] l_data,
  input  logic              l_read,
  input  logic              wide,
  input  logic              compat,
  input  logic              mask_ack,
  output logic              busy,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output bus_cmd_t          cmd,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_data,
  input  logic              rsp_ack,
  output logic              done,
  output logic              done_err,
  output logic [DATA_W-1:0] done_data
);
  typedef enum logic [3:0] {ST_IDLE, ST_START, ST_ADDRW, ST_REG, ST_WHI, ST_WLO,
                            ST_MSTOP, ST_RSTART, ST_ADDRR, ST_RHI, ST_RLO, ST_STOP} st_e;
  st_e               state;
  logic              inflight, rd_q, wide_q, compat_q, mask_q, err_q;
  logic [ADDR_W-1:0] slv_q;
  logic [7:0]        reg_q;
  logic [DATA_W-1:0] dat_q, rx_q;
  logic              wr_state, nack;

  assign busy      = (state != ST_IDLE) || done;
  assign cmd_valid = (state != ST_IDLE) && !inflight;
  assign wr_state  = state inside {ST_ADDRW, ST_REG, ST_WHI, ST_WLO, ST_ADDRR};
  assign nack      = wr_state && !rsp_ack && !mask_q;
  assign done_err  = err_q;
  assign done_data = rx_q;

  always_comb begin
    cmd = '{op: OP_WRITE, data: 8'h00, last: 1'b0};
    case (state)
      ST_START, ST_RSTART: cmd.op = OP_START;
      ST_MSTOP, ST_STOP:   cmd.op = OP_STOP;
      ST_ADDRW:            cmd.data = {slv_q, 1'b0};
      ST_REG:              cmd.data = reg_q;
      ST_WHI:              cmd.data = dat_q[15:8];
      ST_WLO:              cmd.data = dat_q[7:0];
      ST_ADDRR:            cmd.data = {slv_q, 1'b1};
      ST_RHI:              cmd.op = OP_READ;
      ST_RLO:              begin cmd.op = OP_READ; cmd.last = 1'b1; end
      default:             cmd.op = OP_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; inflight <= 1'b0; rd_q <= 1'b0; wide_q <= 1'b0; compat_q <= 1'b0;
      mask_q <= 1'b0; err_q <= 1'b0; slv_q <= '0; reg_q <= '0; dat_q <= '0; rx_q <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE) begin
        if (launch) begin
          state <= ST_START; inflight <= 1'b0; err_q <= 1'b0; rx_q <= '0;
          slv_q <= slave; reg_q <= l_reg; dat_q <= l_data; rd_q <= l_read;
          wide_q <= wide; compat_q <= compat; mask_q <= mask_ack;
        end
      end else if (cmd_valid && cmd_ready) begin
        inflight <= 1'b1;
      end else if (rsp_valid) begin
        inflight <= 1'b0;
        if (nack) begin
          err_q <= 1'b1; state <= ST_STOP;
        end else begin
          case (state)
            ST_START:  state <= ST_ADDRW;
            ST_ADDRW:  state <= ST_REG;
            ST_REG:    state <= rd_q ? (compat_q ? ST_MSTOP : ST_RSTART) : (wide_q ? ST_WHI : ST_WLO);
            ST_WHI:    state <= ST_WLO;
            ST_WLO:    state <= ST_STOP;
            ST_MSTOP:  state <= ST_RSTART;
            ST_RSTART: state <= ST_ADDRR;
            ST_ADDRR:  state <= wide_q ? ST_RHI : ST_RLO;
            ST_RHI:    begin rx_q[15:8] <= rsp_data; state <= ST_RLO; end
            ST_RLO:    begin rx_q[7:0] <= rsp_data; state <= ST_STOP; end
            default:   begin state <= ST_IDLE; done <= 1'b1; end
          endcase
        end
      end
    end
  end

  // R7: a refused byte is followed by STOP
  a_r7_nack_to_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && wr_state && !rsp_ack && !mask_q) |=> (state == ST_STOP));
  // R2: an offered primitive is held until accepted
  a_r2_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd)));
endmodule

// File: rtl/smbus_regs.sv
module smbus_regs import smbus_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              busy,
  input  logic              done,
  input  logic              done_err,
  input  logic [DATA_W-1:0] done_data,
  output logic              launch,
  output logic [31:0]       cfg,
  output logic              irq
);
  logic [DATA_W-1:0] cmd_data;
  logic [7:0]        cmd_reg;
  logic              cmd_rd, wstat, rvalid, err;
  logic [1:0]        ist, imask, ist_clr, ist_set;

  assign launch  = wr_en && (addr == RA_CMD) && cfg[EN_BIT] && !busy;
  assign ist_clr = (wr_en && addr == RA_IST) ? wdata[1:0] : 2'b00;
  assign ist_set = done ? {done_err, 1'b1} : 2'b00;
  assign irq     = |(ist & imask);

  always_comb begin
    case (addr)
      RA_CFG:  rdata = cfg;
      RA_CMD:  rdata = {4'b0, err, rvalid, wstat, cmd_rd, cmd_reg, cmd_data};
      RA_IST:  rdata = {30'b0, ist};
      default: rdata = {30'b0, imask};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0; cmd_data <= '0; cmd_reg <= '0; cmd_rd <= 1'b0; wstat <= 1'b0;
      rvalid <= 1'b0; err <= 1'b0; ist <= '0; imask <= '0;
    end else begin
      ist <= (ist & ~ist_clr) | ist_set;
      if (wr_en && addr == RA_CFG)   cfg <= wdata & CFG_KEEP;
      if (wr_en && addr == RA_IMASK) imask <= wdata[1:0];
      if (launch) begin
        cmd_data <= wdata[DATA_W-1:0];
        cmd_reg  <= wdata[RADDR_LO +: 8];
        cmd_rd   <= wdata[RD_BIT];
        wstat    <= !wdata[RD_BIT];
        rvalid   <= 1'b0;
        err      <= 1'b0;
      end else if (done) begin
        wstat <= 1'b0;
        err   <= done_err;
        if (cmd_rd && !done_err) begin
          rvalid   <= 1'b1;
          cmd_data <= done_data;
        end
      end
    end
  end

  // R4: the write-pending flag only lives inside a transaction
  a_r4_wstat_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wstat |-> busy);
  // R11: command writes while busy leave the fields alone
  a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RA_CMD && busy && !done) |=>
      ($stable(cmd_data) && $stable(cmd_reg) && $stable(cmd_rd)));
  // R9: completion raises the done status bit
  a_r9_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ist[0]);
endmodule

// File: rtl/smbus_byte_master.sv
module smbus_byte_master import smbus_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_in
);
  logic              launch, busy, done, done_err;
  logic [DATA_W-1:0] done_data;
  logic [31:0]       cfg;
  logic              cmd_valid, cmd_ready, tick, restart, rsp_valid, rsp_ack;
  bus_cmd_t          cmd;
  logic [7:0]        rsp_data;

  smbus_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .done(done), .done_err(done_err),
    .done_data(done_data), .launch(launch), .cfg(cfg), .irq(irq));

  smbus_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch),
    .slave(cfg[SLV_LO +: ADDR_W]), .l_reg(reg_wdata[RADDR_LO +: 8]),
    .l_data(reg_wdata[DATA_W-1:0]), .l_read(reg_wdata[RD_BIT]),
    .wide(cfg[WIDE_BIT]), .compat(cfg[COMPAT_BIT]), .mask_ack(cfg[MASK_BIT]),
    .busy(busy), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd(cmd),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ack(rsp_ack),
    .done(done), .done_err(done_err), .done_data(done_data));

  smbus_tick u_tick (
    .clk(clk), .rst_n(rst_n), .restart(restart), .div(cfg[DIV_LO +: DIV_W]), .tick(tick));

  smbus_bit_engine u_eng (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd(cmd),
    .tick(tick), .restart(restart), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_ack(rsp_ack), .scl_drive(scl_oe), .sda_drive(sda_oe), .sda_in(sda_in));

  // R12: lines are released while nothing is running
  a_r12_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/smbus_byte_master_test.sv
`timescale 1ns/1ps
module smbus_byte_master_test;
  logic clk = 0, rst_n = 0, reg_wr = 0, irq, scl_oe, sda_oe, sda_in;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  always #2 clk = ~clk;

  smbus_byte_master uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .sda_in(sda_in));

  // open-drain lines with pull-ups and a behavioural slave
  logic slv_drv = 0;
  wire scl_line = ~scl_oe;
  wire sda_line = ~(sda_oe | slv_drv);
  assign sda_in = sda_line;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  int log_q[0:63]; int log_n = 0;
  int exp_q[0:63]; int exp_n = 0;
  int rise_t[0:7]; int rise_n = 0;
  int nack_idx = -1, rx_idx = 0, tx_idx = 0, bc = 0;
  logic [7:0] rd_bytes[0:1];
  logic [7:0] sh = 0, txb = 0;
  bit active = 0, first = 0, tx = 0, tx_next = 0, mack = 0, p_scl = 1, p_sda = 1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic logit(int v); if (log_n < 64) begin log_q[log_n] = v; log_n++; end endtask

  always @(negedge clk) begin
    automatic bit s = scl_line, d = sda_line;
    if (p_scl && s && p_sda && !d) begin
      active = 1; bc = -1; first = 1; tx = 0; tx_next = 0; slv_drv = 0; logit(256);
    end else if (p_scl && s && !p_sda && d) begin
      if (active) logit(257);
      active = 0; tx = 0; slv_drv = 0;
    end else if (active && !p_scl && s) begin
      if (rise_n < 8) begin rise_t[rise_n] = cyc; rise_n++; end
      if (bc >= 0 && bc < 8 && !tx) sh = {sh[6:0], d};
      if (bc == 8 && tx) mack = !d;
    end else if (active && p_scl && !s) begin
      bc++;
      if (bc == 8) begin
        if (!tx) begin
          logit(sh);
          slv_drv = (rx_idx != nack_idx);
          if (first) begin tx_next = sh[0] && (rx_idx != nack_idx); first = 0; end
          rx_idx++;
        end else slv_drv = 0;
      end else if (bc == 9) begin
        bc = 0;
        if (!tx) begin
          slv_drv = 0;
          if (tx_next) begin
            tx = 1; tx_next = 0; txb = rd_bytes[tx_idx & 1]; tx_idx++; slv_drv = !txb[7];
          end
        end else begin
          logit(mack ? 300 : 301);
          if (mack) begin txb = rd_bytes[tx_idx & 1]; tx_idx++; slv_drv = !txb[7]; end
          else begin tx = 0; slv_drv = 0; end
        end
      end else if (bc >= 1 && bc <= 7 && tx) slv_drv = !txb[7-bc];
    end
    p_scl = s; p_sda = d;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s act=%0h exp=%0h", req, act, exp); end
  endtask

  task automatic hw(logic [1:0] a, logic [31:0] v);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic hr(logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  function automatic logic [31:0] cfg_word(int a7, int div, bit wide, bit mask, bit compat);
    return 32'd1 | (32'(wide) << 1) | (32'(a7 & 8'h7f) << 3) | (32'(div) << 10)
         | (32'(mask) << 22) | (32'(compat) << 23);
  endfunction

  function automatic void ex(int v); exp_q[exp_n] = v; exp_n++; endfunction

  // expected bus log; returns 1 when the transaction should end in error
  function automatic bit build_exp(int a7, int rg, int dat, bit rd, bit wide, bit compat, int nk, bit mask);
    int idx = 0;
    int bytes[0:3]; int nb;
    exp_n = 0; ex(256);
    bytes[0] = (a7 << 1) & 8'hff; bytes[1] = rg;
    if (rd) nb = 2;
    else if (wide) begin bytes[2] = (dat >> 8) & 8'hff; bytes[3] = dat & 8'hff; nb = 4; end
    else begin bytes[2] = dat & 8'hff; nb = 3; end
    for (int i = 0; i < nb; i++) begin
      ex(bytes[i]);
      if (idx == nk && !mask) begin ex(257); return 1; end
      idx++;
    end
    if (rd) begin
      if (compat) ex(257);
      ex(256); ex(((a7 << 1) | 1) & 8'hff);
      if (idx == nk && !mask) begin ex(257); return 1; end
      if (wide) ex(300);
      ex(301);
    end
    ex(257);
    return 0;
  endfunction

  task automatic wait_done(bit rd);
    logic [31:0] v;
    for (int i = 0; i < 40000; i++) begin
      hr(2'd1, v);
      if (rd ? (v[26] | v[27]) : !v[25]) break;
    end
  endtask

  task automatic run_txn(string req, int a7, int rg, int dat, bit rd, bit wide, bit compat,
                         int div, int nk, bit mask, logic [7:0] b0, logic [7:0] b1);
    logic [31:0] v; bit e; int good; logic [15:0] xd;
    nack_idx = nk; rx_idx = 0; tx_idx = 0; rd_bytes[0] = b0; rd_bytes[1] = b1;
    log_n = 0; rise_n = 0;
    e = build_exp(a7, rg, dat, rd, wide, compat, nk, mask);
    hw(2'd0, cfg_word(a7, div, wide, mask, compat));
    hw(2'd1, (rd ? 32'h0 : 32'(dat & 16'hffff)) | (32'(rg & 8'hff) << 16) | (32'(rd) << 24));
    wait_done(rd);
    repeat (4) @(negedge clk);
    good = (log_n == exp_n) ? -1 : log_n;
    for (int i = 0; i < exp_n && good < 0; i++) if (log_q[i] != exp_q[i]) good = i;
    chk(good < 0, req, good < 0 ? 0 : log_q[good], good < 0 ? 0 : exp_q[good]);
    hr(2'd1, v);
    chk(v[27] == e, {req, " R7 error flag"}, v[27], e);
    if (rd) chk(v[26] == !e, {req, " R5 read valid"}, v[26], !e);
    else    chk(v[25] == 0, {req, " R4 pending clear"}, v[25], 0);
    if (!rd) xd = 16'(dat);
    else if (e) xd = 16'h0;
    else xd = wide ? {b0, b1} : {8'h00, b0};
    chk(v[15:0] == xd, {req, " data field"}, v[15:0], xd);
    hr(2'd2, v);
    chk(v[1:0] == {e, 1'b1}, "R9 status bits", v[1:0], {e, 1'b1});
    chk(irq == 1, "R9 irq raised", irq, 1);
    hw(2'd2, 32'h3);
    hr(2'd2, v);
    chk(v[1:0] == 0 && irq == 0, "R9 write-one clear", v[1:0], 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R1 watchdog expired act=0 exp=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk); rst_n = 1;
    // R12 reset state
    for (int a = 0; a < 4; a++) begin hr(2'(a), v); chk(v == 0, "R12 register reset", v, 0); end
    chk(irq == 0 && scl_oe == 0 && sda_oe == 0, "R12 lines released", {irq, scl_oe, sda_oe}, 0);
    // R1 disabled block ignores command
    log_n = 0;
    hw(2'd1, 32'h0012_0034);
    repeat (60) @(negedge clk);
    hr(2'd1, v);
    chk(v == 0 && log_n == 0, "R1 disabled ignore", v, 0);
    hw(2'd3, 32'h1);
    // R2 narrow write and R10 timing
    run_txn("R2 narrow write", 7'h21, 8'h5a, 16'h00c3, 0, 0, 0, 3, -1, 0, 0, 0);
    chk(rise_t[3] - rise_t[2] == 8, "R10 period div3", rise_t[3] - rise_t[2], 8);
    run_txn("R10 div0 write", 7'h42, 8'h01, 16'h0081, 0, 0, 0, 0, -1, 0, 0, 0);
    chk(rise_t[3] - rise_t[2] == 4, "R10 period div0", rise_t[3] - rise_t[2], 4);
    run_txn("R5 narrow read", 7'h30, 8'h11, 0, 1, 0, 0, 2, -1, 0, 8'hb6, 8'h00);
    run_txn("R6 compat read", 7'h30, 8'h12, 0, 1, 0, 1, 2, -1, 0, 8'h6d, 8'h00);
    run_txn("R3 wide write", 7'h1c, 8'h77, 16'hbeef, 0, 1, 0, 1, -1, 0, 0, 0);
    run_txn("R3 wide read", 7'h1c, 8'h78, 0, 1, 1, 0, 1, -1, 0, 8'ha5, 8'h3c);
    run_txn("R7 nack address", 7'h05, 8'h20, 16'h0011, 0, 0, 0, 1, 0, 0, 0, 0);
    run_txn("R7 nack register", 7'h05, 8'h21, 16'h0012, 0, 0, 0, 1, 1, 0, 0, 0);
    run_txn("R7 nack read address", 7'h05, 8'h22, 0, 1, 0, 0, 1, 2, 0, 8'h99, 0);
    run_txn("R8 masked nack", 7'h05, 8'h23, 16'h0044, 0, 0, 0, 1, 0, 1, 0, 0);
    // R9 mask gating
    hw(2'd3, 32'h0);
    hw(2'd0, cfg_word(7'h10, 1, 0, 0, 0));
    hw(2'd1, 32'h0033_0001);
    wait_done(0); repeat (4) @(negedge clk);
    hr(2'd2, v);
    chk(v[0] == 1 && irq == 0, "R9 masked irq", irq, 0);
    hw(2'd2, 32'h3); hw(2'd3, 32'h1);
    // R11 busy ignore and R4 status read-only
    log_n = 0; rx_idx = 0; nack_idx = -1;
    void'(build_exp(7'h10, 8'h40, 16'h00aa, 0, 0, 0, -1, 0));
    hw(2'd0, cfg_word(7'h10, 2, 0, 0, 0));
    hw(2'd1, 32'h0c40_00aa);
    hr(2'd1, v);
    chk(v[27:25] == 3'b001, "R4 pending set, status read-only", v[27:25], 1);
    repeat (30) @(negedge clk);
    hw(2'd1, 32'h0055_1234);
    wait_done(0); repeat (4) @(negedge clk);
    hr(2'd1, v);
    chk(v[23:0] == 24'h4000aa, "R11 fields kept", v[23:0], 24'h4000aa);
    chk(log_n == exp_n && log_q[3] == 8'haa, "R11 bus unchanged", log_n, exp_n);
    hw(2'd2, 32'h3);
    // random mix
    for (int n = 0; n < 30; n++) begin
      automatic bit rd = 1'($urandom), wide = 1'($urandom), cp = 1'($urandom);
      automatic int nk = ($urandom % 6 == 0) ? int'($urandom % 3) : -1;
      run_txn("R2 R3 R5 random", int'($urandom % 128), int'($urandom % 256),
              int'($urandom % 65536), rd, wide, cp, int'($urandom % 7), nk, 0,
              8'($urandom), 8'($urandom));
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule